// File: doc/BRIEF.md
# Serial Divide-by-Three Engine

This block divides a binary number by three while the number streams in one bit per clock, most significant bit first. Each accepted bit moves a three-state remainder machine one step. The quotient bit for that position is produced from the same step. Read in arrival order, the quotient bits are the binary quotient of the whole number divided by three, and the remainder output holds the number modulo three at every point in the stream.

A producer drives the data bit together with a valid strobe. It raises a start flag with the first bit of a new number, or on its own to clear the machine between numbers. Quotient bits come out with a matching valid flag on the clock after the bit that produced them. No word assembly takes place: the consumer collects the serial quotient itself. The machine has one step rule. The next remainder is (2·r + d) mod 3, and the quotient bit is high when 2·r + d is 3 or more.

Top module: `div3_serial`

## Requirements
- R1: A synchronous active-high `rst` at a rising edge sets `rem` to 0 and `q_vld` and `q_bit` to 0, whatever `in_vld` and `start` are.
- R2: With remainder 0 (encoding 2'b00) and an accepted bit d, the new remainder is d (0 stays 2'b00, 1 gives 2'b01) and the quotient bit is 0.
- R3: With remainder 1 (encoding 2'b01), an accepted 0 gives remainder 2 (2'b10) with quotient bit 0, and an accepted 1 gives remainder 0 with quotient bit 1.
- R4: With remainder 2 (encoding 2'b10), an accepted 0 gives remainder 1 and an accepted 1 keeps remainder 2. Both give quotient bit 1.
- R5: In a cycle with `in_vld` low and `start` low, `rem` keeps its value. On the next edge `q_vld` and `q_bit` go to 0.
- R6: `start` high with `in_vld` low clears `rem` to 0 at the edge and produces no quotient bit.
- R7: `start` high with `in_vld` high processes the bit as the first bit of a new number, starting from remainder 0.
- R8: Outputs are registered. After the edge that accepts a bit, `q_vld` is 1, `q_bit` is the quotient bit for that position, and `rem` is the new remainder. For any number fed MSB first after a start, the quotient bits equal N/3 MSB first and the final `rem` equals N mod 3.
- R9: `rem` never shows the unused encoding 2'b11. Were that state ever entered, the next accepted bit would be handled as if the remainder were 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new number (clears remainder) |
| in_vld | input | 1 | Data bit valid strobe |
| in_bit | input | 1 | Serial dividend bit, MSB first |
| q_bit | output | 1 | Registered quotient bit |
| q_vld | output | 1 | Quotient bit valid |
| rem | output | 2 | Running remainder: 00, 01 or 10 |

## Verification
A short vector walk visits all six transitions of the remainder machine, so a swapped next state or a wrong quotient on any single arc is seen. It also includes an idle cycle, a start-only cycle and a start that coincides with a valid bit, which separate holding, clearing and restarting. Whole 8-bit numbers are then streamed: 0, 3, 255, alternating-bit patterns and a value with remainder 2. These separate a correct quotient from one that is only right on divisible inputs or only on the first bits. One stream has valid gaps in it to show that idle cycles do not disturb the result, and one stream is reset in the middle while a bit is valid.

// File: rtl/div3_pkg.sv
package div3_pkg;

  localparam int REM_W = 2;

  typedef logic [REM_W-1:0] rem_t;

  localparam rem_t REM_ZERO = 2'b00;
  localparam rem_t REM_ONE  = 2'b01;
  localparam rem_t REM_TWO  = 2'b10;

  typedef struct packed {
    rem_t nxt;
    logic quo;
  } step_t;

endpackage

// File: rtl/div3_step_logic.sv
module div3_step_logic
  import div3_pkg::*;
(
  input  rem_t  cur_rem,
  input  logic  restart,
  input  logic  din,
  output step_t res
);

  rem_t base;

  // a new number, or the illegal code, starts from remainder zero
  always_comb begin
    if (restart || cur_rem == 2'b11) base = REM_ZERO;
    else                             base = cur_rem;
  end

  // Mealy step: result depends on the state and the incoming bit
  always_comb begin
    res = '{nxt: REM_ZERO, quo: 1'b0};
    unique case (base)
      REM_ZERO: res = din ? '{nxt: REM_ONE,  quo: 1'b0} : '{nxt: REM_ZERO, quo: 1'b0};
      REM_ONE:  res = din ? '{nxt: REM_ZERO, quo: 1'b1} : '{nxt: REM_TWO,  quo: 1'b0};
      REM_TWO:  res = din ? '{nxt: REM_TWO,  quo: 1'b1} : '{nxt: REM_ONE,  quo: 1'b1};
      default:  res = '{nxt: REM_ZERO, quo: 1'b0};
    endcase
  end

endmodule

// File: rtl/div3_state_reg.sv
module div3_state_reg
  import div3_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  take,
  input  step_t step,
  output rem_t  rem_q,
  output logic  quo_q,
  output logic  vld_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= REM_ZERO;
      quo_q <= 1'b0;
      vld_q <= 1'b0;
    end else if (take) begin
      rem_q <= step.nxt;
      quo_q <= step.quo;
      vld_q <= 1'b1;
    end else begin
      if (start) rem_q <= REM_ZERO;
      quo_q <= 1'b0;
      vld_q <= 1'b0;
    end
  end

endmodule

// File: rtl/div3_serial.sv
module div3_serial
  import div3_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_vld,
  input  logic             in_bit,
  output logic             q_bit,
  output logic             q_vld,
  output logic [REM_W-1:0] rem
);

  rem_t  rem_r;
  step_t step_w;

  div3_step_logic u_step (
    .cur_rem (rem_r),
    .restart (start),
    .din     (in_bit),
    .res     (step_w)
  );

  div3_state_reg u_state (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .take  (in_vld),
    .step  (step_w),
    .rem_q (rem_r),
    .quo_q (q_bit),
    .vld_q (q_vld)
  );

  assign rem = rem_r;

endmodule

// File: rtl/div3_serial_chk.sv
module div3_serial_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       in_vld,
  input logic       in_bit,
  input logic       q_bit,
  input logic       q_vld,
  input logic [1:0] rem
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (rem == 2'b00 && !q_vld && !q_bit)); // R1
  AST_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !start && rem == 2'b00) |=> (!q_bit && rem == {1'b0, $past(in_bit)})); // R2
  AST_FROM_ONE_HI: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !start && rem == 2'b01 && in_bit) |=> (q_bit && rem == 2'b00)); // R3
  AST_FROM_ONE_LO: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !start && rem == 2'b01 && !in_bit) |=> (!q_bit && rem == 2'b10)); // R3
  AST_FROM_TWO: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !start && rem == 2'b10) |=> q_bit); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !start) |=> ($stable(rem) && !q_vld && !q_bit)); // R5
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (start && !in_vld) |=> (rem == 2'b00 && !q_vld)); // R6
  AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
    (start && in_vld) |=> (!q_bit && rem == {1'b0, $past(in_bit)})); // R7
  AST_VLD_TRACKS: assert property (@(posedge clk) disable iff (rst) in_vld |=> q_vld); // R8
  AST_NO_ILLEGAL: assert property (@(posedge clk) disable iff (rst) rem != 2'b11); // R9

endmodule

bind div3_serial div3_serial_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .in_vld (in_vld),
  .in_bit (in_bit),
  .q_bit  (q_bit),
  .q_vld  (q_vld),
  .rem    (rem)
);

// File: tb/div3_serial_tb_top.sv
`timescale 1ns/1ps
module div3_serial_tb_top;

  logic clk = 1'b0;
  logic rst, start, in_vld, in_bit;
  logic q_bit, q_vld;
  logic [1:0] rem;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  div3_serial dut_i (
    .clk(clk), .rst(rst), .start(start), .in_vld(in_vld), .in_bit(in_bit),
    .q_bit(q_bit), .q_vld(q_vld), .rem(rem)
  );

  // {start, vld, bit, rem[1:0], q, qv}
  localparam int NVEC = 14;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_1_0_00_0_1, // R2 0 -> 0
    7'b0_1_1_01_0_1, // R2 0 -> 1
    7'b0_1_0_10_0_1, // R3 1 -> 2
    7'b0_1_1_10_1_1, // R4 2 -> 2
    7'b0_1_0_01_1_1, // R4 2 -> 1
    7'b0_1_1_00_1_1, // R3 1 -> 0
    7'b0_1_1_01_0_1, // R2
    7'b0_0_1_01_0_0, // R5 idle
    7'b1_0_0_00_0_0, // R6 start only
    7'b0_1_1_01_0_1, // R2
    7'b0_1_0_10_0_1, // R3
    7'b1_1_1_01_0_1, // R7 restart with bit
    7'b0_1_1_00_1_1, // R3
    7'b0_1_0_00_0_1  // R2
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic v, input logic b, input logic r = 1'b0);
    @(negedge clk);
    start = s; in_vld = v; in_bit = b; rst = r;
    @(posedge clk);
    #1;
    start = 1'b0; in_vld = 1'b0; rst = 1'b0;
  endtask

  task automatic stream(input logic [7:0] n, input bit gaps);
    logic [7:0] qe;
    qe = n / 8'd3;
    for (int i = 7; i >= 0; i--) begin
      step(i == 7, 1'b1, n[i]);
      check(q_vld === 1'b1 && q_bit === qe[i], "R8 quotient bit", int'(q_bit), int'(qe[i]));
      if (gaps && i % 3 == 0) begin
        step(1'b0, 1'b0, ~n[i]);
        check(q_vld === 1'b0, "R5 gap", int'(q_vld), 0);
      end
    end
    check(rem === 2'(n % 8'd3), "R8 final remainder", int'(rem), int'(n % 8'd3));
  endtask

  initial begin
    #400000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; in_vld = 1'b0; in_bit = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check(rem === 2'b00 && q_vld === 1'b0 && q_bit === 1'b0, "R1 reset state", int'(rem), 0);
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][6], VEC[k][5], VEC[k][4]);
      check(rem === VEC[k][3:2], "R2/R3/R4/R5/R6/R7 table rem", int'(rem), int'(VEC[k][3:2]));
      check(q_bit === VEC[k][1] && q_vld === VEC[k][0], "R8 table quotient",
            int'({q_bit, q_vld}), int'(VEC[k][1:0]));
      check(rem !== 2'b11, "R9 legal encoding", int'(rem), 0);
    end

    stream(8'd0, 1'b0);
    stream(8'd3, 1'b0);
    stream(8'd255, 1'b0);
    stream(8'h55, 1'b0);
    stream(8'hAA, 1'b1);
    stream(8'd200, 1'b0);
    stream(8'd131, 1'b1);

    step(1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    check(rem === 2'b10, "R3 before reset", int'(rem), 2);
    step(1'b0, 1'b1, 1'b1, 1'b1);
    check(rem === 2'b00 && q_vld === 1'b0, "R1 reset over valid", int'(rem), 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule